// File: doc/BRIEF.md
# Seconds Real-Time Clock with Alarm

This block keeps a 32-bit count of elapsed seconds. It runs directly from a slow reference clock and sits on a simple word-addressed register bus that is synchronous to that same clock. A programmable trim value sets how many reference cycles make up one second. A trim of 0x8000 on a 32768 Hz reference gives one increment per second. A trim of zero stops the clock.

Software can load the seconds count with any value, for example zero to restart timekeeping. Software also sets an alarm compare value. When an increment brings the count to that value, a sticky alarm flag is raised. Every increment also raises a sticky tick flag. Each flag has its own enable, and the interrupt line is asserted while any enabled flag is set. An alarm value of all ones is reserved to mean "no alarm" and never fires.

Word offsets on `bus_addr`: 0 alarm compare, 1 seconds count, 2 trim, 3 unused, 4 status/control. Status bits: bit 0 alarm flag, bit 1 tick flag, bit 2 alarm interrupt enable, bit 3 tick interrupt enable.

Top module: `secrtc_top`

## Requirements
- R1: After reset the alarm register reads 0xFFFFFFFF, the count reads 0, the trim reads 0, the status reads 0 and `irq` is low.
- R2: With trim T > 0, the count increments once every T reference cycles. Writing the trim restarts the divider, so the first increment lands on the T-th rising edge after the write edge.
- R3: With trim 0, the count never changes on its own.
- R4: A write to offset 1 loads the count with the written value. If that write lands in the same cycle as an increment, the write wins. The count wraps from 0xFFFFFFFF to 0.
- R5: Status bit 0 (alarm flag) sets when an increment makes the count equal to the alarm register. Loading the count directly with the alarm value does not set it.
- R6: An alarm register value of 0xFFFFFFFF never sets the alarm flag, even when the count steps onto 0xFFFFFFFF.
- R7: Status bit 1 (tick flag) sets on every increment.
- R8: Writing status clears each flag (bits 0 and 1) whose written bit is 1 and leaves flags written with 0 untouched. An event in the same cycle as its clear leaves the flag set.
- R9: Bits 2 and 3 of a status write are stored as the alarm and tick interrupt enables and read back in place.
- R10: `irq` is high exactly when (alarm flag and alarm enable) or (tick flag and tick enable).
- R11: Offset 3 and offsets 5 to 7 read as zero and ignore writes. Trim bits above the trim width read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, also the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench times increments edge by edge for trims of 1 and 4, and rewrites the trim partway through a period. A divider that does not restart, or that is off by one in its reload, shows up as an increment one cycle early or late. It lands a count write and a W1C clear exactly on an increment edge. A wrong priority makes the count read one too high, or makes a tick flag vanish. It drives the count through the all-ones wrap with the all-ones "never" alarm in place, and it loads the count directly with the alarm value. A comparator that watches the stored count instead of the increment would raise a spurious alarm in either case.

// File: rtl/secrtc_pkg.sv
package secrtc_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  // word offsets on the bus
  typedef enum logic [ADDR_W-1:0] {
    OFS_ALARM = 3'd0,
    OFS_COUNT = 3'd1,
    OFS_TRIM  = 3'd2,
    OFS_GAP   = 3'd3,
    OFS_STAT  = 3'd4
  } secrtc_ofs_e;

  // status word bit positions
  localparam int ST_ALARM_FLAG = 0;
  localparam int ST_TICK_FLAG  = 1;
  localparam int ST_ALARM_EN   = 2;
  localparam int ST_TICK_EN    = 3;
  localparam int N_EVENTS      = 2;

  // sticky flag update: a new event outranks a clear in the same cycle
  function automatic logic f_sticky(input logic flag, input logic evt, input logic clr);
    return evt | (flag & ~clr);
  endfunction

endpackage

// File: rtl/secrtc_prescaler.sv
module secrtc_prescaler #(
  parameter int TRIM_W    = 16,
  parameter int TRIM_INIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trim_wr,
  input  logic [TRIM_W-1:0] trim_wdata,
  output logic [TRIM_W-1:0] trim_q,
  output logic              tick
);

  localparam logic [TRIM_W-1:0] TRIM_RST = TRIM_W'(TRIM_INIT);

  // divider start value for a given trim; zero trim parks at zero
  function automatic logic [TRIM_W-1:0] f_reload(input logic [TRIM_W-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  logic [TRIM_W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q <= TRIM_RST;
      div_q  <= f_reload(TRIM_RST);
    end else if (trim_wr) begin
      trim_q <= trim_wdata;
      div_q  <= f_reload(trim_wdata);
    end else if (trim_q == '0) begin
      div_q  <= '0;
    end else if (div_q == '0) begin
      div_q  <= f_reload(trim_q);
    end else begin
      div_q  <= div_q - 1'b1;
    end
  end

  // one reference cycle pulse when the divider expires; a trim write restarts it
  assign tick = (trim_q != '0) && (div_q == '0) && !trim_wr;

endmodule

// File: rtl/secrtc_seconds.sv
module secrtc_seconds #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             alarm_wr,
  input  logic             count_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] alarm_q,
  output logic [CNT_W-1:0] count_q,
  output logic             alarm_hit
);

  localparam logic [CNT_W-1:0] NEVER = '1;

  function automatic logic [CNT_W-1:0] f_step(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  function automatic logic f_match(input logic [CNT_W-1:0] nxt, input logic [CNT_W-1:0] alm);
    return (nxt == alm) && (alm != NEVER);
  endfunction

  logic [CNT_W-1:0] count_inc;
  logic             step_en;

  assign count_inc = f_step(count_q);
  assign step_en   = tick && !count_wr;
  assign alarm_hit = step_en && f_match(count_inc, alarm_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (count_wr) begin
      count_q <= wdata;
    end else if (step_en) begin
      count_q <= count_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_q <= NEVER;
    end else if (alarm_wr) begin
      alarm_q <= wdata;
    end
  end

endmodule

// File: rtl/secrtc_status.sv
module secrtc_status
  import secrtc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stat_wr,
  input  logic [3:0]          stat_wdata,
  input  logic [N_EVENTS-1:0] evt,
  output logic [N_EVENTS-1:0] flags_q,
  output logic [N_EVENTS-1:0] en_q,
  output logic                irq
);

  logic [N_EVENTS-1:0] clr;
  logic [N_EVENTS-1:0] active;

  assign clr = stat_wr ? stat_wdata[N_EVENTS-1:0] : '0;

  for (genvar g = 0; g < N_EVENTS; g++) begin : g_evt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flags_q[g] <= 1'b0;
        en_q[g]    <= 1'b0;
      end else begin
        flags_q[g] <= f_sticky(flags_q[g], evt[g], clr[g]);
        if (stat_wr) en_q[g] <= stat_wdata[N_EVENTS+g];
      end
    end
    assign active[g] = flags_q[g] & en_q[g];
  end

  assign irq = |active;

endmodule

// File: rtl/secrtc_regs.sv
module secrtc_regs
  import secrtc_pkg::*;
(
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] alarm_q,
  input  logic [DATA_W-1:0] count_q,
  input  logic [DATA_W-1:0] trim_word,
  input  logic [DATA_W-1:0] stat_word,
  output logic              wr_alarm,
  output logic              wr_count,
  output logic              wr_trim,
  output logic              wr_stat,
  output logic [DATA_W-1:0] bus_rdata
);

  logic wr_any;
  assign wr_any   = bus_sel && bus_wr;
  assign wr_alarm = wr_any && (bus_addr == OFS_ALARM);
  assign wr_count = wr_any && (bus_addr == OFS_COUNT);
  assign wr_trim  = wr_any && (bus_addr == OFS_TRIM);
  assign wr_stat  = wr_any && (bus_addr == OFS_STAT);

  always_comb begin
    case (bus_addr)
      OFS_ALARM: bus_rdata = alarm_q;
      OFS_COUNT: bus_rdata = count_q;
      OFS_TRIM:  bus_rdata = trim_word;
      OFS_STAT:  bus_rdata = stat_word;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/secrtc_top.sv
module secrtc_top
  import secrtc_pkg::*;
#(
  parameter int TRIM_W    = 16,
  parameter int TRIM_INIT = 0
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int PAD_W = DATA_W - TRIM_W;

  logic                wr_alarm, wr_count, wr_trim, wr_stat;
  logic [TRIM_W-1:0]   trim_q;
  logic                tick;
  logic                alarm_hit;
  logic [DATA_W-1:0]   alarm_q, count_q;
  logic [N_EVENTS-1:0] flags_q, en_q, evt;
  logic [DATA_W-1:0]   trim_word, stat_word;

  assign evt[ST_ALARM_FLAG] = alarm_hit;
  assign evt[ST_TICK_FLAG]  = tick;
  assign trim_word = {{PAD_W{1'b0}}, trim_q};
  assign stat_word = {{(DATA_W-2*N_EVENTS){1'b0}}, en_q, flags_q};

  secrtc_regs u_regs (
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .alarm_q   (alarm_q),
    .count_q   (count_q),
    .trim_word (trim_word),
    .stat_word (stat_word),
    .wr_alarm  (wr_alarm),
    .wr_count  (wr_count),
    .wr_trim   (wr_trim),
    .wr_stat   (wr_stat),
    .bus_rdata (bus_rdata)
  );

  secrtc_prescaler #(.TRIM_W(TRIM_W), .TRIM_INIT(TRIM_INIT)) u_presc (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .trim_wr    (wr_trim),
    .trim_wdata (bus_wdata[TRIM_W-1:0]),
    .trim_q     (trim_q),
    .tick       (tick)
  );

  secrtc_seconds #(.CNT_W(DATA_W)) u_secs (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .tick      (tick),
    .alarm_wr  (wr_alarm),
    .count_wr  (wr_count),
    .wdata     (bus_wdata),
    .alarm_q   (alarm_q),
    .count_q   (count_q),
    .alarm_hit (alarm_hit)
  );

  secrtc_status u_stat (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .stat_wr    (wr_stat),
    .stat_wdata (bus_wdata[3:0]),
    .evt        (evt),
    .flags_q    (flags_q),
    .en_q       (en_q),
    .irq        (irq)
  );

endmodule

// File: rtl/secrtc_checker.sv
module secrtc_checker #(
  parameter int TRIM_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wr_count,
  input logic [31:0]       wdata,
  input logic [31:0]       count_q,
  input logic [31:0]       alarm_q,
  input logic [TRIM_W-1:0] trim_q,
  input logic [1:0]        flags_q,
  input logic [1:0]        en_q,
  input logic              irq
);

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_count |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + 32'd1));

  a_r3_zero_trim_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (trim_q == '0 && !wr_count) |=> count_q == $past(count_q));

  a_r4_count_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_count |=> count_q == $past(wdata));

  a_r5_alarm_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_q[0] && !tick) |=> !flags_q[0]);

  a_r6_never_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_q == 32'hFFFF_FFFF && !flags_q[0]) |=> !flags_q[0]);

  a_r7_tick_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> flags_q[1]);

  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & en_q) == 2'b00) |-> !irq);

  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((flags_q[0] && en_q[0]) || (flags_q[1] && en_q[1])));

endmodule

bind secrtc_top secrtc_checker #(.TRIM_W(TRIM_W)) u_chk (
  .clk      (clk_ref),
  .rst_n    (rst_n),
  .tick     (tick),
  .wr_count (wr_count),
  .wdata    (bus_wdata),
  .count_q  (count_q),
  .alarm_q  (alarm_q),
  .trim_q   (trim_q),
  .flags_q  (flags_q),
  .en_q     (en_q),
  .irq      (irq)
);

// File: tb/test_secrtc_top.sv
module test_secrtc_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] A_ALM = 3'd0, A_CNT = 3'd1, A_TRM = 3'd2, A_GAP = 3'd3, A_STS = 3'd4;

  logic        clk_ref = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 0;

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  secrtc_top i_secrtc_top (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk_ref);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk_ref);
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_ALM, d); chk("R1 alarm", d, 32'hFFFF_FFFF);
    rd(A_CNT, d); chk("R1 count", d, 32'h0);
    rd(A_TRM, d); chk("R1 trim", d, 32'h0);
    rd(A_STS, d); chk("R1 status", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_trim_idle();
    logic [31:0] d;
    wr(A_TRM, 0); wr(A_CNT, 77);
    idle(50);
    rd(A_CNT, d); chk("R3 zero trim holds count", d, 77);
  endtask

  task automatic t_prescale();
    logic [31:0] d;
    wr(A_TRM, 0); wr(A_CNT, 0);
    wr(A_TRM, 4);
    idle(3); rd(A_CNT, d); chk("R2 before 4th edge", d, 0);
    idle(1); rd(A_CNT, d); chk("R2 on 4th edge", d, 1);
    idle(4); rd(A_CNT, d); chk("R2 second period", d, 2);
    idle(2); wr(A_TRM, 4);
    idle(3); rd(A_CNT, d); chk("R2 restart delays", d, 2);
    idle(1); rd(A_CNT, d); chk("R2 restart lands", d, 3);
    wr(A_TRM, 0); wr(A_CNT, 0); wr(A_TRM, 1);
    idle(5); rd(A_CNT, d); chk("R2 trim one every edge", d, 5);
  endtask

  task automatic t_count_write();
    logic [31:0] d;
    wr(A_TRM, 0); wr(A_CNT, 100); wr(A_TRM, 4);
    idle(3); wr(A_CNT, 500);
    rd(A_CNT, d); chk("R4 write beats tick", d, 500);
    idle(3); rd(A_CNT, d); chk("R4 held after load", d, 500);
    idle(1); rd(A_CNT, d); chk("R4 resumes", d, 501);
  endtask

  task automatic t_wrap_never();
    logic [31:0] d;
    wr(A_TRM, 0); wr(A_ALM, 32'hFFFF_FFFF); wr(A_CNT, 32'hFFFF_FFFE); wr(A_STS, 32'h3);
    wr(A_TRM, 4);
    idle(4); rd(A_CNT, d); chk("R4 reaches all ones", d, 32'hFFFF_FFFF);
    rd(A_STS, d); chk("R6 no alarm at all ones", d & 32'h1, 32'h0);
    idle(4); rd(A_CNT, d); chk("R4 wraps to zero", d, 0);
    rd(A_STS, d); chk("R6 still no alarm", d & 32'h1, 32'h0);
    chk("R7 tick flag set", d & 32'h2, 32'h2);
  endtask

  task automatic t_alarm();
    logic [31:0] d;
    wr(A_TRM, 0); wr(A_ALM, 50); wr(A_STS, 32'h3); wr(A_CNT, 50);
    idle(2); rd(A_STS, d); chk("R5 direct load no alarm", d & 32'h1, 32'h0);
    wr(A_ALM, 12); wr(A_CNT, 10); wr(A_STS, 32'h7);
    wr(A_TRM, 4);
    idle(7); rd(A_STS, d); chk("R5 not yet", d & 32'h1, 32'h0);
    chk("R10 tick flag not enabled", {31'b0, irq}, 32'h0);
    idle(1); rd(A_STS, d); chk("R5 alarm on increment", d & 32'h1, 32'h1);
    chk("R10 irq from alarm", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(A_TRM, 0); wr(A_ALM, 3); wr(A_CNT, 2); wr(A_STS, 32'h3);
    wr(A_TRM, 1); idle(1); wr(A_TRM, 0);
    rd(A_STS, d); chk("R8 both flags set", d, 32'h3);
    wr(A_STS, 32'h6); rd(A_STS, d); chk("R8 clear tick only", d, 32'h5);
    chk("R10 irq alarm enabled", {31'b0, irq}, 32'h1);
    wr(A_STS, 32'h4); rd(A_STS, d); chk("R9 zero bits keep flags", d, 32'h5);
    wr(A_STS, 32'h5); rd(A_STS, d); chk("R8 clear alarm", d, 32'h4);
    chk("R10 irq drops", {31'b0, irq}, 32'h0);
    wr(A_STS, 32'h3); wr(A_TRM, 4); idle(3); wr(A_STS, 32'h2);
    rd(A_STS, d); chk("R8 event beats clear", d & 32'h2, 32'h2);
    wr(A_TRM, 0); wr(A_STS, 32'h8);
    chk("R10 irq tick enabled", {31'b0, irq}, 32'h1);
    rd(A_STS, d); chk("R9 tick enable reads back", d, 32'hA);
    wr(A_STS, 32'h0);
    chk("R10 irq disabled", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_gap();
    logic [31:0] d;
    wr(A_GAP, 32'hDEAD_BEEF); rd(A_GAP, d); chk("R11 gap reads zero", d, 0);
    wr(3'd6, 32'h1234_5678); rd(3'd6, d); chk("R11 high offset zero", d, 0);
    wr(A_TRM, 32'h0001_2345); rd(A_TRM, d); chk("R11 trim upper bits", d, 32'h2345);
    wr(A_TRM, 0);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk_ref);
    #1 rst_n = 1'b1;
    t_reset();
    t_trim_idle();
    t_prescale();
    t_count_write();
    t_wrap_never();
    t_alarm();
    t_w1c();
    t_gap();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule